// File: doc/BRIEF.md
# Configuration Header Register File

This block stores a 256-byte configuration header for a bus endpoint or bridge. The header is held as 64 registers of 32 bits, and each register has a per-bit mask that says which bits software may change. Elaboration parameters set the identity fields: vendor and device identifiers, class and subclass, and whether the header describes a bridge. Parameters also set up to six base-address slots. Each slot has a base, a power-of-two size and a memory-or-IO flag.

Writes arrive as a byte, a 16-bit half or a full dword, at a byte offset. The new data is merged into the stored register through that register's mask. Each base-address slot gets a mask derived from its size. When all ones are written to a slot, it therefore reads back its size mask together with its fixed type bits. Reads are always a full dword, addressed by dword index. They return one cycle later with a valid strobe. A separate sideband input loads the interrupt line and pin fields.

Top module: `cfgsp_regfile`

## Requirements
- R1: A synchronous active-low reset loads the following values. Register 0 holds the device ID in bits 31:16 and the vendor ID in bits 15:0. Register 2 holds the class in bits 31:24, the subclass in bits 23:16 and zero below. Register 3 holds 0x0001_0000 for a bridge header and 0 otherwise. Every other register that is not a base-address slot holds 0.
- R2: A read request on `rd_en` with dword index `rd_idx` raises `rd_valid` for exactly one cycle, one cycle later, with the register contents in `rd_data`. A write to the same register in the same cycle does not affect that read, which returns the old value. `rd_valid` is low in a cycle that follows no request.
- R3: A read of an index of 64 or more returns 0xFFFF_FFFF. A write whose dword index (byte offset / 4) is 64 or more changes no register.
- R4: A dword write (`wr_size`=2) replaces only the bits that are set in the register's mask. The low two offset bits are ignored. Registers other than the base-address slots are fully writable.
- R5: A half write (`wr_size`=1) takes `wr_data[15:0]`. It lands in bits 15:0 when offset mod 4 is 0 and in bits 31:16 when offset mod 4 is 2. It is ignored when offset mod 4 is 1 or 3.
- R6: A byte write (`wr_size`=0) takes `wr_data[7:0]` and lands at bits 8*(offset mod 4) of register offset/4, through the same mask. The other three bytes are unchanged.
- R7: Base-address slot k occupies register 4+k. A configured memory slot resets to base AND 0xFFFF_FFF0. A configured IO slot resets to (base AND 0xFFFF_FFFC) OR 1.
- R8: The mask of a configured slot is the bitwise inverse of (size-1). Writing all ones therefore reads back ~(size-1) OR the stored bits below the size.
- R9: Some slots are unconfigured: slot k with k >= NUM_BARS, and any slot whose size is not a power of two or whose base+size exceeds 2^32. Such a slot reads 0 and has an all-zero mask, so writes leave it at 0.
- R10: `irq_set` loads register 15. Bits 7:0 take `irq_line`. Bits 15:8 take `irq_pin`+1, where pin code 0..3 stands for pins A..D and is stored as 1..4. Bits 31:16 keep their value. When a register write to register 15 happens in the same cycle, the sideband wins for bits 15:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_size | input | 2 | 0 byte, 1 half, 2 dword; 3 ignored |
| wr_addr | input | 10 | Write byte offset |
| wr_data | input | 32 | Write data, right-aligned for byte and half |
| rd_en | input | 1 | Read request |
| rd_idx | input | 8 | Read dword index |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data |
| irq_set | input | 1 | Load interrupt line and pin fields |
| irq_line | input | 8 | Interrupt line value |
| irq_pin | input | 2 | Interrupt pin code, 0 = A |

## Verification
Several properties are checked by assertions on every cycle. The read strobe follows the request by exactly one cycle. An out-of-range read returns all ones. An unconfigured base-address slot reads zero. Bits outside each register's mask never change. The sideband load writes the line and the one-based pin into register 15. Other behaviour needs the bench's scenarios to show it: the exact merge results for every access width and lane, the ignored odd half offsets, the size readback after all-ones writes, the old value returned on a same-cycle read and write, and the restore of all parameterized values after a later reset.

// File: rtl/cfgsp_pkg.sv
// Shared encodings, fixed register positions and elaboration-time helpers
// for the configuration header register file. Assumes 32-bit registers.
package cfgsp_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_HALF  = 2'd1,
        ACC_DWORD = 2'd2
    } acc_size_e;

    localparam int BAR_FIRST = 4;   // first base-address register
    localparam int MAX_BARS  = 6;   // slots available
    localparam int IRQ_REG   = 15;  // interrupt line / pin register

    // A slot is legal when its size is a power of two and it fits under 2^32.
    function automatic logic bar_is_legal(logic [31:0] base, logic [31:0] size);
        logic [32:0] top_end;
        top_end = {1'b0, base} + {1'b0, size};
        return (size != 32'd0) && ((size & (size - 32'd1)) == 32'd0) &&
               (top_end <= 33'h1_0000_0000);
    endfunction

    // Reset contents of a configured slot: aligned base plus type bits.
    function automatic logic [31:0] bar_reset_value(logic [31:0] base, logic is_io);
        return is_io ? ((base & 32'hFFFF_FFFC) | 32'h1) : (base & 32'hFFFF_FFF0);
    endfunction

    // Writable bits of a configured slot: everything at or above the size bit.
    function automatic logic [31:0] bar_write_mask(logic [31:0] size);
        return ~(size - 32'd1);
    endfunction

endpackage

// File: rtl/cfgsp_init_table.sv
// Elaboration-time table of reset values and writable masks for every
// register. It is pure constant logic. It assumes NUM_REG covers the
// identity, base-address and interrupt registers (at least 16).
module cfgsp_init_table #(
    parameter int              NUM_REG   = 64,
    parameter logic [15:0]     VENDOR_ID = 16'h0000,
    parameter logic [15:0]     DEVICE_ID = 16'h0000,
    parameter logic [7:0]      CLASS_ID  = 8'h00,
    parameter logic [7:0]      SUBCLASS  = 8'h00,
    parameter bit              IS_BRIDGE = 1'b0,
    parameter int              NUM_BARS  = 0,
    parameter logic [5:0][31:0] BAR_BASE = '0,
    parameter logic [5:0][31:0] BAR_SIZE = '0,
    parameter logic [5:0]      BAR_IO    = '0
) (
    output logic [NUM_REG-1:0][31:0] init_val,
    output logic [NUM_REG-1:0][31:0] wmask
);
    import cfgsp_pkg::*;

    // One branch per register class, chosen by its index.
    for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
        if (g == 0) begin : g_ident
            assign init_val[g] = {DEVICE_ID, VENDOR_ID};
            assign wmask[g]    = '1;
        end else if (g == 2) begin : g_class
            assign init_val[g] = {CLASS_ID, SUBCLASS, 16'h0000};
            assign wmask[g]    = '1;
        end else if (g == 3) begin : g_hdr
            assign init_val[g] = IS_BRIDGE ? 32'h0001_0000 : 32'h0;
            assign wmask[g]    = '1;
        end else if (g >= BAR_FIRST && g < BAR_FIRST + MAX_BARS) begin : g_bar
            localparam int  SLOT = g - BAR_FIRST;
            localparam bit  USED = (SLOT < NUM_BARS) &&
                                   bar_is_legal(BAR_BASE[SLOT], BAR_SIZE[SLOT]);
            assign init_val[g] = USED ? bar_reset_value(BAR_BASE[SLOT], BAR_IO[SLOT]) : 32'h0;
            assign wmask[g]    = USED ? bar_write_mask(BAR_SIZE[SLOT]) : 32'h0;
        end else begin : g_plain
            assign init_val[g] = 32'h0;
            assign wmask[g]    = '1;
        end
    end

endmodule

// File: rtl/cfgsp_lane_merge.sv
// Merges a byte, half or dword write into one stored register through its
// writable mask. It assumes write data is right-aligned. A half write at an
// odd lane and an unknown size are refused (accept low).
module cfgsp_lane_merge (
    input  logic [1:0]  size,
    input  logic [1:0]  lane_sel,
    input  logic [31:0] data,
    input  logic [31:0] old_val,
    input  logic [31:0] wmask,
    output logic [31:0] new_val,
    output logic        accept
);
    import cfgsp_pkg::*;

    logic [31:0] lane;
    logic [31:0] dsh;
    logic [31:0] eff;

    // Build the lane mask and the shifted data for the access width.
    always_comb begin
        lane   = '0;
        dsh    = '0;
        accept = 1'b0;
        case (acc_size_e'(size))
            ACC_BYTE: begin
                lane   = 32'h0000_00FF << {lane_sel, 3'b000};
                dsh    = {24'h0, data[7:0]} << {lane_sel, 3'b000};
                accept = 1'b1;
            end
            ACC_HALF: begin
                if (!lane_sel[0]) begin
                    lane   = 32'h0000_FFFF << {lane_sel[1], 4'b0000};
                    dsh    = {16'h0, data[15:0]} << {lane_sel[1], 4'b0000};
                    accept = 1'b1;
                end
            end
            ACC_DWORD: begin
                lane   = '1;
                dsh    = data;
                accept = 1'b1;
            end
            default: accept = 1'b0;
        endcase
    end

    // Keep every bit outside lane-and-mask, take the data inside it.
    always_comb begin
        eff     = lane & wmask;
        new_val = (old_val & ~eff) | (dsh & eff);
    end

endmodule

// File: rtl/cfgsp_reg_array.sv
// Storage for all registers. Sync active-low reset loads the table values.
// One merged write per cycle. The interrupt sideband overrides bits 15:0 of
// its register after any same-cycle write.
module cfgsp_reg_array #(
    parameter int NUM_REG   = 64,
    localparam int REG_IDX_W = $clog2(NUM_REG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REG-1:0][31:0]  init_val,
    input  logic                      wr_hit,
    input  logic [REG_IDX_W-1:0]      wr_reg,
    input  logic [31:0]               wr_val,
    input  logic                      irq_set,
    input  logic [7:0]                irq_line,
    input  logic [1:0]                irq_pin,
    output logic [NUM_REG-1:0][31:0]  regs_q
);
    import cfgsp_pkg::*;

    for (genvar g = 0; g < NUM_REG; g++) begin : g_cell
        if (g == IRQ_REG) begin : g_irq
            // Register write, then sideband line/pin load on top of it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs_q[g] <= init_val[g];
                end else begin
                    if (wr_hit && wr_reg == REG_IDX_W'(g))
                        regs_q[g] <= wr_val;
                    if (irq_set)
                        regs_q[g][15:0] <= {({6'b0, irq_pin} + 8'd1), irq_line};
                end
            end
        end else begin : g_std
            // Plain register: load on a write aimed at it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_q[g] <= init_val[g];
                else if (wr_hit && wr_reg == REG_IDX_W'(g))
                    regs_q[g] <= wr_val;
            end
        end
    end

endmodule

// File: rtl/cfgsp_regfile.sv
// Top of the configuration header register file. It decodes the write
// offset, drops out-of-range accesses, merges through the mask and serves
// registered dword reads (one-cycle latency, old value on collision).
module cfgsp_regfile #(
    parameter int               NUM_REG   = 64,
    parameter int               ADDR_W    = 10,
    parameter logic [15:0]      VENDOR_ID = 16'h1D0F,
    parameter logic [15:0]      DEVICE_ID = 16'h0042,
    parameter logic [7:0]       CLASS_ID  = 8'h02,
    parameter logic [7:0]       SUBCLASS  = 8'h00,
    parameter bit               IS_BRIDGE = 1'b0,
    parameter int               NUM_BARS  = 2,
    parameter logic [5:0][31:0] BAR_BASE  = {32'h0, 32'h0, 32'h0, 32'h0,
                                             32'h0000_1000, 32'h8000_0000},
    parameter logic [5:0][31:0] BAR_SIZE  = {32'h0, 32'h0, 32'h0, 32'h0,
                                             32'h0000_0100, 32'h0001_0000},
    parameter logic [5:0]       BAR_IO    = 6'b000010,
    localparam int IDX_W     = ADDR_W - 2,
    localparam int REG_IDX_W = $clog2(NUM_REG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_size,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic              irq_set,
    input  logic [7:0]        irq_line,
    input  logic [1:0]        irq_pin
);
    logic [NUM_REG-1:0][31:0] init_val;
    logic [NUM_REG-1:0][31:0] wmask;
    logic [NUM_REG-1:0][31:0] regs_q;
    logic [IDX_W-1:0]         wr_idx;
    logic                     wr_in_range;
    logic [REG_IDX_W-1:0]     wr_reg;
    logic [31:0]              merged;
    logic                     lane_ok;
    logic                     wr_hit;

    cfgsp_init_table #(
        .NUM_REG(NUM_REG), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
        .CLASS_ID(CLASS_ID), .SUBCLASS(SUBCLASS), .IS_BRIDGE(IS_BRIDGE),
        .NUM_BARS(NUM_BARS), .BAR_BASE(BAR_BASE), .BAR_SIZE(BAR_SIZE),
        .BAR_IO(BAR_IO)
    ) u_table (
        .init_val(init_val),
        .wmask   (wmask)
    );

    // Split the byte offset into dword index and lane; flag out-of-range.
    always_comb begin
        wr_idx      = wr_addr[ADDR_W-1:2];
        wr_in_range = int'(wr_idx) < NUM_REG;
        wr_reg      = wr_idx[REG_IDX_W-1:0];
    end

    cfgsp_lane_merge u_merge (
        .size    (wr_size),
        .lane_sel(wr_addr[1:0]),
        .data    (wr_data),
        .old_val (regs_q[wr_reg]),
        .wmask   (wmask[wr_reg]),
        .new_val (merged),
        .accept  (lane_ok)
    );

    // A write commits only when in range and the lane is legal.
    always_comb wr_hit = wr_en && wr_in_range && lane_ok;

    cfgsp_reg_array #(.NUM_REG(NUM_REG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_val(init_val),
        .wr_hit  (wr_hit),
        .wr_reg  (wr_reg),
        .wr_val  (merged),
        .irq_set (irq_set),
        .irq_line(irq_line),
        .irq_pin (irq_pin),
        .regs_q  (regs_q)
    );

    // Registered read port; samples pre-write contents, all ones past the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_data <= (int'(rd_idx) < NUM_REG) ? regs_q[rd_idx[REG_IDX_W-1:0]] : 32'hFFFF_FFFF;
        end
    end

endmodule

// File: rtl/cfgsp_checker.sv
// Cycle-by-cycle properties of the register file, bound to the top. It
// observes ports, the stored registers and the mask table.
module cfgsp_checker #(
    parameter int NUM_REG  = 64,
    parameter int IDX_W    = 8,
    parameter int NUM_BARS = 0
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     rd_en,
    input logic [IDX_W-1:0]         rd_idx,
    input logic                     rd_valid,
    input logic [31:0]              rd_data,
    input logic                     irq_set,
    input logic [7:0]               irq_line,
    input logic [1:0]               irq_pin,
    input logic [NUM_REG-1:0][31:0] regs_q,
    input logic [NUM_REG-1:0][31:0] wmask
);
    import cfgsp_pkg::*;

    // R2: strobe follows a request by one cycle, and only then.
    p_rd_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    p_no_rd_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R3: reads past the end return all ones.
    p_oor_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(rd_idx) >= NUM_REG) |=> rd_data == 32'hFFFF_FFFF);

    // R9: unused base-address slots read zero.
    p_unconf_bar_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(rd_idx) >= BAR_FIRST + NUM_BARS &&
         int'(rd_idx) < BAR_FIRST + MAX_BARS) |=> rd_data == 32'h0);

    // R10: sideband load puts line and one-based pin into the register.
    p_irq_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> (regs_q[IRQ_REG][7:0] == $past(irq_line)) &&
                    (regs_q[IRQ_REG][15:8] == ({6'b0, $past(irq_pin)} + 8'd1)));

    // R4 / R8: bits outside a register's mask never move.
    for (genvar g = 0; g < NUM_REG; g++) begin : g_hold
        if (g != IRQ_REG) begin : g_chk
            p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $stable(regs_q[g] & ~wmask[g]));
        end
    end

endmodule

bind cfgsp_regfile cfgsp_checker #(
    .NUM_REG(NUM_REG), .IDX_W(IDX_W), .NUM_BARS(NUM_BARS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq_set(irq_set),
    .irq_line(irq_line), .irq_pin(irq_pin), .regs_q(regs_q), .wmask(wmask)
);

// File: tb/cfgsp_regfile_bench.sv
// Vector-table bench for the configuration header register file, followed
// by directed collision, sideband and reset tests.
module cfgsp_regfile_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_size = 2'd0;
    logic [9:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_idx = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        irq_set = 1'b0;
    logic [7:0]  irq_line = '0;
    logic [1:0]  irq_pin = '0;

    int applied = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    cfgsp_regfile #(
        .VENDOR_ID(16'hABCD), .DEVICE_ID(16'h1234), .CLASS_ID(8'h04),
        .SUBCLASS(8'h01), .IS_BRIDGE(1'b1), .NUM_BARS(4),
        .BAR_BASE({32'h0, 32'h0, 32'hFFFF_F000, 32'h2000_0000, 32'h0000_C000, 32'h1000_0000}),
        .BAR_SIZE({32'h0, 32'h0, 32'h0000_2000, 32'h0000_3000, 32'h0000_0020, 32'h0000_1000}),
        .BAR_IO(6'b000010)
    ) u_cfgsp_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size(wr_size),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq_set(irq_set),
        .irq_line(irq_line), .irq_pin(irq_pin)
    );

    typedef struct packed {
        logic        is_rd;
        logic [1:0]  sz;
        logic [9:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam logic [1:0] B = 2'd0, H = 2'd1, D = 2'd2;
    localparam int NV = 48;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b1, D, 10'h000, 32'h0, 32'h1234_ABCD, 4'd1},  // R1 identity
        '{1'b1, D, 10'h008, 32'h0, 32'h0401_0000, 4'd1},  // R1 class
        '{1'b1, D, 10'h00C, 32'h0, 32'h0001_0000, 4'd1},  // R1 bridge header
        '{1'b1, D, 10'h03C, 32'h0, 32'h0000_0000, 4'd1},  // R1 plain reg
        '{1'b1, D, 10'h010, 32'h0, 32'h1000_0000, 4'd7},  // R7 memory slot
        '{1'b1, D, 10'h014, 32'h0, 32'h0000_C001, 4'd7},  // R7 IO slot
        '{1'b1, D, 10'h018, 32'h0, 32'h0000_0000, 4'd9},  // R9 non-pow2
        '{1'b1, D, 10'h01C, 32'h0, 32'h0000_0000, 4'd9},  // R9 overflow
        '{1'b1, D, 10'h020, 32'h0, 32'h0000_0000, 4'd9},  // R9 beyond count
        '{1'b1, D, 10'h024, 32'h0, 32'h0000_0000, 4'd9},  // R9
        '{1'b0, D, 10'h010, 32'hFFFF_FFFF, 32'h0, 4'd8},  // R8 size probe
        '{1'b1, D, 10'h010, 32'h0, 32'hFFFF_F000, 4'd8},
        '{1'b0, D, 10'h014, 32'hFFFF_FFFF, 32'h0, 4'd8},  // R8 IO probe
        '{1'b1, D, 10'h014, 32'h0, 32'hFFFF_FFE1, 4'd8},
        '{1'b0, D, 10'h018, 32'hFFFF_FFFF, 32'h0, 4'd9},  // R9 write ignored
        '{1'b1, D, 10'h018, 32'h0, 32'h0000_0000, 4'd9},
        '{1'b0, D, 10'h020, 32'hFFFF_FFFF, 32'h0, 4'd9},
        '{1'b1, D, 10'h020, 32'h0, 32'h0000_0000, 4'd9},
        '{1'b0, D, 10'h010, 32'h2000_0ABC, 32'h0, 4'd8},  // R8 reprogram
        '{1'b1, D, 10'h010, 32'h0, 32'h2000_0000, 4'd8},
        '{1'b0, D, 10'h040, 32'hDEAD_BEEF, 32'h0, 4'd4},  // R4 full write
        '{1'b1, D, 10'h040, 32'h0, 32'hDEAD_BEEF, 4'd4},
        '{1'b0, H, 10'h042, 32'h0000_5555, 32'h0, 4'd5},  // R5 upper half
        '{1'b1, D, 10'h040, 32'h0, 32'h5555_BEEF, 4'd5},
        '{1'b0, H, 10'h040, 32'hFFFF_1111, 32'h0, 4'd5},  // R5 lower half
        '{1'b1, D, 10'h040, 32'h0, 32'h5555_1111, 4'd5},
        '{1'b0, H, 10'h041, 32'h0000_AAAA, 32'h0, 4'd5},  // R5 odd offset
        '{1'b0, H, 10'h043, 32'h0000_BBBB, 32'h0, 4'd5},  // R5 odd offset
        '{1'b1, D, 10'h040, 32'h0, 32'h5555_1111, 4'd5},
        '{1'b0, B, 10'h043, 32'h0000_0077, 32'h0, 4'd6},  // R6 lane 3
        '{1'b0, B, 10'h041, 32'hFFFF_FF22, 32'h0, 4'd6},  // R6 lane 1
        '{1'b1, D, 10'h040, 32'h0, 32'h7755_2211, 4'd6},
        '{1'b0, B, 10'h012, 32'h0000_00FF, 32'h0, 4'd8},  // R8 byte in slot
        '{1'b1, D, 10'h010, 32'h0, 32'h20FF_0000, 4'd8},
        '{1'b0, B, 10'h010, 32'h0000_00FF, 32'h0, 4'd8},  // R8 masked lane
        '{1'b1, D, 10'h010, 32'h0, 32'h20FF_0000, 4'd8},
        '{1'b0, B, 10'h011, 32'h0000_00FF, 32'h0, 4'd8},  // R8 partial lane
        '{1'b1, D, 10'h010, 32'h0, 32'h20FF_F000, 4'd8},
        '{1'b0, D, 10'h100, 32'h0000_0000, 32'h0, 4'd3},  // R3 write dropped
        '{1'b1, D, 10'h000, 32'h0, 32'h1234_ABCD, 4'd3},
        '{1'b1, D, 10'h100, 32'h0, 32'hFFFF_FFFF, 4'd3},  // R3 read idx 64
        '{1'b1, D, 10'h320, 32'h0, 32'hFFFF_FFFF, 4'd3},  // R3 read idx 200
        '{1'b0, B, 10'h3FF, 32'h0000_0055, 32'h0, 4'd3},  // R3 far byte
        '{1'b1, D, 10'h0FC, 32'h0, 32'h0000_0000, 4'd3},
        '{1'b0, D, 10'h002, 32'h0000_0000, 32'h0, 4'd4},  // R4 low bits ignored
        '{1'b1, D, 10'h000, 32'h0, 32'h0000_0000, 4'd4},
        '{1'b0, D, 10'h03C, 32'hCAFE_0000, 32'h0, 4'd4},  // R4 prep for R10
        '{1'b1, D, 10'h03C, 32'h0, 32'hCAFE_0000, 4'd4}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] sz, input logic [9:0] addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_size = sz; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = idx;
        @(negedge clk);
        rd_en = 1'b0;
        check({tag, " valid"}, {31'b0, rd_valid}, 32'h1);
        check(tag, rd_data, exp);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle after reset", {31'b0, rd_valid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_rd)
                do_read(VEC[i].addr[9:2], VEC[i].exp, $sformatf("R%0d vec %0d", VEC[i].req, i));
            else
                do_write(VEC[i].sz, VEC[i].addr, VEC[i].data);
        end

        // R2: strobe drops in the cycle after a read with no new request.
        @(negedge clk);
        check("R2 no strobe", {31'b0, rd_valid}, 32'h0);

        // R2: same-cycle write and read of register 16 returns old value.
        @(negedge clk);
        wr_en = 1'b1; wr_size = D; wr_addr = 10'h040; wr_data = 32'h0BAD_0BAD;
        rd_en = 1'b1; rd_idx = 8'd16;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R2 collision old", rd_data, 32'h7755_2211);
        do_read(8'd16, 32'h0BAD_0BAD, "R2 collision new");

        // R10: sideband sets line and pin C, upper half preserved.
        @(negedge clk);
        irq_set = 1'b1; irq_line = 8'h0B; irq_pin = 2'd2;
        @(negedge clk);
        irq_set = 1'b0;
        do_read(8'd15, 32'hCAFE_030B, "R10 sideband");

        // R10: sideband beats a same-cycle register write on bits 15:0.
        @(negedge clk);
        irq_set = 1'b1; irq_line = 8'h05; irq_pin = 2'd0;
        wr_en = 1'b1; wr_size = D; wr_addr = 10'h03C; wr_data = 32'h1234_5678;
        @(negedge clk);
        irq_set = 1'b0; wr_en = 1'b0;
        do_read(8'd15, 32'h1234_0105, "R10 priority");

        // R1: a later reset restores every parameterized value.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_read(8'd4, 32'h1000_0000, "R1 slot restore");
        do_read(8'd5, 32'h0000_C001, "R1 IO restore");
        do_read(8'd0, 32'h1234_ABCD, "R1 identity restore");
        do_read(8'd16, 32'h0000_0000, "R1 plain restore");
        do_read(8'd15, 32'h0000_0000, "R1 irq restore");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

endmodule